// File: doc/BRIEF.md
# PHY Bring-Up Sequencer

This block is a hardware state machine that brings a serial-link PHY from reset to a running state without any software writes. After a start command it lets the PHY out of reset, points the PHY configuration port at the PLL-lock register and enables lane 0. It then waits for the PLL to lock and issues two strobed configuration writes. Next it waits for the PLL output flag to go low. Last, it points the configuration port back at the lock register and waits for the PLL to lock again. Each of the three waits has its own timeout. A timeout puts the PHY back into reset and raises a sticky error.

Each wait polls its status input at a fixed interval, and an overall timeout bounds it. The configuration writes hold address and data for a setup period before the strobe is raised, and they hold the strobe for the same period. All three periods are parameters given in clock cycles. A separate power-off command turns lane 0 off and then puts the PHY into reset.

States: `S_OFF` (PHY in reset, lane off), `S_LOCK1` (first lock wait), `S_WSETUP` and `S_WPULSE` (setup and strobe phases of write 0 and write 1), `S_DROP` (wait for the PLL output flag to fall), `S_LOCK2` (relock wait), `S_DONE` (one-cycle success), `S_ON` (running), `S_FAIL` (timeout, PHY in reset) and `S_PDOWN` (lane off, reset not yet applied).

Transitions:
- `S_OFF`/`S_FAIL` to `S_LOCK1` on start.
- `S_LOCK1` to `S_WSETUP` on a lock sample.
- `S_WSETUP` to `S_WPULSE` when the setup period ends.
- `S_WPULSE` to `S_WSETUP` after write 0, or to `S_DROP` after write 1.
- `S_DROP` to `S_LOCK2` when the output flag is sampled low.
- `S_LOCK2` to `S_DONE` on a lock sample.
- `S_DONE` to `S_ON`.
- Any wait state to `S_FAIL` on timeout.
- Any state other than `S_OFF` to `S_PDOWN` on power-off.
- `S_PDOWN` to `S_OFF`.

Top module: `phy_bringup_seq`

## Requirements
- R1: After reset the PHY reset output and lane-off output are high. The config address, data, strobe, done and error outputs are all zero.
- R2: A start command accepted in the off state releases the PHY reset in the next cycle. In that same cycle lane-off drops, and the config port shows address 0x10 with data 0.
- R3: Each wait samples its condition in its first cycle and then every POLL_CYC cycles. It advances on the first sample that meets the condition. PLL lock is sampled in the first wait.
- R4: After the first lock, the block performs two writes, first to address 0x10 and then to 0x12, both with data 0x8 (bit 3 set). Each write holds address and data for STEP_CYC cycles with the strobe low, then raises the strobe for STEP_CYC cycles. Address and data stay stable while the strobe is high.
- R5: After the second write, the block waits until the PLL output flag is sampled at 0. It then drives address 0x10 again and waits for PLL lock a second time.
- R6: On the second lock, done is high for exactly one cycle. After that, the PHY reset stays released with address 0x10 until a power-off command arrives.
- R7: If a wait has not advanced by its TIMEOUT_CYC-th cycle, the PHY reset is high from the following cycle. Error is then held high until a start or power-off command.
- R8: A start command received during the sequence or in the running state has no effect.
- R9: Power-off raises lane-off for one cycle with the PHY reset still released, then raises the PHY reset. Power-off takes priority over start and has no effect in the off state.
- R10: A start command in the failed state clears error and restarts the sequence from the first lock wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin the bring-up sequence |
| pwr_off_i | input | 1 | Power the lane down and reset the PHY |
| pll_locked_i | input | 1 | PLL lock status from the PHY |
| pll_output_i | input | 1 | PLL output status flag from the PHY |
| phy_rst_o | output | 1 | PHY reset, high = held in reset |
| lane_off_o | output | 1 | Lane 0 disable, high = off |
| cfg_addr_o | output | 6 | PHY configuration address |
| cfg_data_o | output | 4 | PHY configuration data |
| cfg_wr_o | output | 1 | PHY configuration write strobe |
| done_o | output | 1 | One-cycle success pulse |
| err_o | output | 1 | Timeout error, sticky until start or power-off |

## Verification
The assertions check the local rules on every cycle:
- the strobe carries a legal address with data 0x8 and stable fields;
- done is a single-cycle pulse with the PHY out of reset;
- error always comes with reset and persists;
- a start seen while in reset releases it;
- lane-off always precedes a power-off reset.

The timing of the whole sequence can only be shown by the bench's scenarios. That timing covers when each poll sample falls, the exact cycle of done or failure for lock arriving late, dropping out or never, and the timeout boundary. The scenarios also show that a start during a wait does not restart the timer.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

    typedef enum logic [3:0] {
        S_OFF,
        S_LOCK1,
        S_WSETUP,
        S_WPULSE,
        S_DROP,
        S_LOCK2,
        S_DONE,
        S_ON,
        S_FAIL,
        S_PDOWN
    } seq_state_e;

    localparam int CFG_AW = 6;
    localparam int CFG_DW = 4;

    // PHY register addresses and the value written during reconfiguration
    localparam logic [CFG_AW-1:0] ADDR_LOCK = 6'h10;
    localparam logic [CFG_AW-1:0] ADDR_CLK  = 6'h12;
    localparam logic [CFG_DW-1:0] CFG_VAL   = 4'h8;

endpackage

// File: rtl/seq_wait_timer.sv
module seq_wait_timer #(
    parameter int POLL_CYC    = 6250,
    parameter int TIMEOUT_CYC = 2500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic poll_tick,
    output logic expired
);
    localparam int PW = (POLL_CYC > 1) ? $clog2(POLL_CYC) : 1;
    localparam int TW = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC) : 1;
    localparam logic [PW-1:0] P_LAST = PW'(POLL_CYC - 1);
    localparam logic [TW-1:0] T_LAST = TW'(TIMEOUT_CYC - 1);

    logic [PW-1:0] pcnt;
    logic [TW-1:0] tcnt;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pcnt <= '0;
            tcnt <= '0;
        end else begin
            pcnt <= (pcnt == P_LAST) ? '0 : pcnt + 1'b1;
            if (tcnt != T_LAST) begin
                tcnt <= tcnt + 1'b1;
            end
        end
    end

    assign poll_tick = (pcnt == '0);
    assign expired   = (tcnt == T_LAST);

endmodule

// File: rtl/seq_step_timer.sv
module seq_step_timer #(
    parameter int STEP_CYC = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic step_done
);
    localparam int SW = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
    localparam logic [SW-1:0] S_LAST = SW'(STEP_CYC - 1);

    logic [SW-1:0] scnt;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            scnt <= '0;
        end else if (scnt != S_LAST) begin
            scnt <= scnt + 1'b1;
        end
    end

    assign step_done = (scnt == S_LAST);

endmodule

// File: rtl/phy_bringup_seq.sv
module phy_bringup_seq
    import phy_seq_pkg::*;
#(
    parameter int POLL_CYC    = 6250,
    parameter int TIMEOUT_CYC = 2500000,
    parameter int STEP_CYC    = 125
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              pwr_off_i,
    input  logic              pll_locked_i,
    input  logic              pll_output_i,
    output logic              phy_rst_o,
    output logic              lane_off_o,
    output logic [CFG_AW-1:0] cfg_addr_o,
    output logic [CFG_DW-1:0] cfg_data_o,
    output logic              cfg_wr_o,
    output logic              done_o,
    output logic              err_o
);
    seq_state_e state_q, state_d;
    logic       wr_idx_q, wr_idx_d;
    logic       leave;
    logic       poll_tick, expired, step_done;

    // any state change restarts both timers
    assign leave = (state_d != state_q);

    seq_wait_timer #(
        .POLL_CYC   (POLL_CYC),
        .TIMEOUT_CYC(TIMEOUT_CYC)
    ) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (leave),
        .poll_tick(poll_tick),
        .expired  (expired)
    );

    seq_step_timer #(
        .STEP_CYC(STEP_CYC)
    ) u_step (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (leave),
        .step_done(step_done)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= S_OFF;
            wr_idx_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            wr_idx_q <= wr_idx_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        wr_idx_d = wr_idx_q;
        if (pwr_off_i) begin
            state_d = (state_q == S_OFF || state_q == S_PDOWN) ? S_OFF : S_PDOWN;
        end else begin
            unique case (state_q)
                S_OFF, S_FAIL: begin
                    if (start_i) state_d = S_LOCK1;
                end
                S_LOCK1: begin
                    if (poll_tick && pll_locked_i) begin
                        state_d  = S_WSETUP;
                        wr_idx_d = 1'b0;
                    end else if (expired) begin
                        state_d = S_FAIL;
                    end
                end
                S_WSETUP: begin
                    if (step_done) state_d = S_WPULSE;
                end
                S_WPULSE: begin
                    if (step_done) begin
                        if (wr_idx_q) begin
                            state_d = S_DROP;
                        end else begin
                            state_d  = S_WSETUP;
                            wr_idx_d = 1'b1;
                        end
                    end
                end
                S_DROP: begin
                    if (poll_tick && !pll_output_i) state_d = S_LOCK2;
                    else if (expired)               state_d = S_FAIL;
                end
                S_LOCK2: begin
                    if (poll_tick && pll_locked_i) state_d = S_DONE;
                    else if (expired)              state_d = S_FAIL;
                end
                S_DONE:  state_d = S_ON;
                S_ON:    state_d = S_ON;
                S_PDOWN: state_d = S_OFF;
                default: state_d = S_OFF;
            endcase
        end
    end

    always_comb begin
        phy_rst_o  = 1'b0;
        lane_off_o = 1'b0;
        cfg_addr_o = ADDR_LOCK;
        cfg_data_o = CFG_VAL;
        cfg_wr_o   = 1'b0;
        done_o     = 1'b0;
        err_o      = 1'b0;
        unique case (state_q)
            S_OFF: begin
                phy_rst_o  = 1'b1;
                lane_off_o = 1'b1;
                cfg_addr_o = '0;
                cfg_data_o = '0;
            end
            S_LOCK1: cfg_data_o = '0;
            S_WSETUP: cfg_addr_o = wr_idx_q ? ADDR_CLK : ADDR_LOCK;
            S_WPULSE: begin
                cfg_addr_o = wr_idx_q ? ADDR_CLK : ADDR_LOCK;
                cfg_wr_o   = 1'b1;
            end
            S_DROP:  cfg_addr_o = ADDR_CLK;
            S_LOCK2, S_ON: ;
            S_DONE:  done_o = 1'b1;
            S_FAIL: begin
                phy_rst_o  = 1'b1;
                err_o      = 1'b1;
                cfg_addr_o = '0;
                cfg_data_o = '0;
            end
            S_PDOWN: begin
                lane_off_o = 1'b1;
                cfg_addr_o = '0;
                cfg_data_o = '0;
            end
            default: phy_rst_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/phy_seq_checker.sv
module phy_seq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       pwr_off_i,
    input logic       phy_rst_o,
    input logic       lane_off_o,
    input logic [5:0] cfg_addr_o,
    input logic [3:0] cfg_data_o,
    input logic       cfg_wr_o,
    input logic       done_o,
    input logic       err_o
);
    a_r2_start_releases: assert property (@(posedge clk) disable iff (!rst_n)
        phy_rst_o && start_i && !pwr_off_i |=> !phy_rst_o && !lane_off_o && !err_o);

    a_r4_strobe_fields: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_o |-> cfg_data_o == 4'h8 && (cfg_addr_o == 6'h10 || cfg_addr_o == 6'h12));

    a_r4_strobe_stable: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_o |-> $stable(cfg_addr_o) && $stable(cfg_data_o));

    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r6_done_released: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !phy_rst_o && cfg_addr_o == 6'h10 && !cfg_wr_o);

    a_r7_err_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> phy_rst_o);

    a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_o && !start_i && !pwr_off_i |=> err_o);

    a_r9_lane_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phy_rst_o) && !err_o |-> $past(lane_off_o));

    a_r9_pdown_short: assert property (@(posedge clk) disable iff (!rst_n)
        lane_off_o && !phy_rst_o |=> phy_rst_o && lane_off_o);

endmodule

bind phy_bringup_seq phy_seq_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .pwr_off_i (pwr_off_i),
    .phy_rst_o (phy_rst_o),
    .lane_off_o(lane_off_o),
    .cfg_addr_o(cfg_addr_o),
    .cfg_data_o(cfg_data_o),
    .cfg_wr_o  (cfg_wr_o),
    .done_o    (done_o),
    .err_o     (err_o)
);

// File: tb/tb_phy_bringup_seq.sv
module tb_phy_bringup_seq;
    localparam int POLL  = 4;
    localparam int TMO   = 40;
    localparam int STEP  = 3;
    localparam int NEVER = 9999;
    localparam int NSCN  = 9;

    // L: lock rises, X..Y: lock dropout, O: output flag falls, exp_err, exp_cycle
    localparam int SCN [NSCN][6] = '{
        '{0,     NEVER, NEVER, 0,     0, 15},
        '{5,     NEVER, NEVER, 0,     0, 23},
        '{NEVER, NEVER, NEVER, 0,     1, 40},
        '{0,     NEVER, NEVER, NEVER, 1, 53},
        '{0,     5,     NEVER, 0,     1, 54},
        '{0,     5,     17,    0,     0, 19},
        '{0,     NEVER, NEVER, 20,    0, 23},
        '{36,    NEVER, NEVER, 0,     0, 51},
        '{37,    NEVER, NEVER, 0,     1, 40}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0, pwr_off_i = 1'b0;
    logic       pll_locked_i = 1'b0, pll_output_i = 1'b1;
    logic       phy_rst_o, lane_off_o, cfg_wr_o, done_o, err_o;
    logic [5:0] cfg_addr_o;
    logic [3:0] cfg_data_o;

    always #4 clk = ~clk;

    phy_bringup_seq #(.POLL_CYC(POLL), .TIMEOUT_CYC(TMO), .STEP_CYC(STEP)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .pwr_off_i(pwr_off_i),
        .pll_locked_i(pll_locked_i), .pll_output_i(pll_output_i),
        .phy_rst_o(phy_rst_o), .lane_off_o(lane_off_o), .cfg_addr_o(cfg_addr_o),
        .cfg_data_o(cfg_data_o), .cfg_wr_o(cfg_wr_o), .done_o(done_o), .err_o(err_o)
    );

    int checks = 0, fails = 0;
    int got_err, got_cyc, rises, wr_cyc, bad_data;
    logic [5:0] pa0, pa1;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    task automatic power_down();
        @(negedge clk); pwr_off_i = 1'b1;
        @(negedge clk); pwr_off_i = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic run_scn(input int l, input int x, input int y, input int o, input int restart_at);
        logic prev_wr;
        @(negedge clk); start_i = 1'b1; pll_locked_i = 1'b0; pll_output_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        got_err = -1; got_cyc = -1; rises = 0; wr_cyc = 0; bad_data = 0; prev_wr = 1'b0;
        pa0 = '0; pa1 = '0;
        for (int c = 0; c < 150; c++) begin
            pll_locked_i = (c >= l) && !(c >= x && c < y);
            pll_output_i = (c < o);
            start_i      = (c == restart_at);
            if (cfg_wr_o) begin
                wr_cyc++;
                if (cfg_data_o != 4'h8) bad_data++;
                if (!prev_wr) begin
                    if (rises == 0) pa0 = cfg_addr_o; else pa1 = cfg_addr_o;
                    rises++;
                end
            end
            prev_wr = cfg_wr_o;
            if (done_o || err_o) begin
                got_err = int'(err_o);
                got_cyc = c;
                break;
            end
            @(negedge clk);
        end
        start_i = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(phy_rst_o == 1'b1 && lane_off_o == 1'b1, "R1", "reset/lane_off", {phy_rst_o, lane_off_o}, 3);
        chk(cfg_addr_o == 0 && cfg_data_o == 0 && !cfg_wr_o, "R1", "cfg port", int'(cfg_addr_o), 0);
        chk(!done_o && !err_o, "R1", "done/err", {done_o, err_o}, 0);

        // R9: power-off beats start in the off state
        start_i = 1'b1; pwr_off_i = 1'b1;
        @(negedge clk); start_i = 1'b0; pwr_off_i = 1'b0;
        chk(phy_rst_o == 1'b1 && lane_off_o == 1'b1, "R9", "off with start+poweroff", int'(phy_rst_o), 1);

        // R2: first cycle after start
        start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        chk(!phy_rst_o && !lane_off_o, "R2", "reset/lane released", {phy_rst_o, lane_off_o}, 0);
        chk(cfg_addr_o == 6'h10 && cfg_data_o == 0, "R2", "lock address selected", int'(cfg_addr_o), 16);
        power_down();

        // table of scenarios: R3 R5 R6 R7
        for (int i = 0; i < NSCN; i++) begin
            power_down();
            run_scn(SCN[i][0], SCN[i][1], SCN[i][2], SCN[i][3], -1);
            chk(got_err == SCN[i][4], "R3/R5/R7", $sformatf("scn%0d outcome", i), got_err, SCN[i][4]);
            chk(got_cyc == SCN[i][5], "R3/R5/R7", $sformatf("scn%0d cycle", i), got_cyc, SCN[i][5]);
            if (SCN[i][4] == 0) begin
                chk(rises == 2 && pa0 == 6'h10 && pa1 == 6'h12, "R4", "write addresses",
                    int'(pa1), 18);
                chk(wr_cyc == 2 * STEP && bad_data == 0, "R4", "strobe cycles", wr_cyc, 2 * STEP);
                chk(!phy_rst_o, "R6", "reset released at done", int'(phy_rst_o), 0);
                @(negedge clk);
                chk(!done_o && !phy_rst_o && cfg_addr_o == 6'h10, "R6", "done one cycle, running",
                    int'(done_o), 0);
                // R8: start in running state has no effect
                start_i = 1'b1; @(negedge clk); start_i = 1'b0;
                repeat (3) @(negedge clk);
                chk(!phy_rst_o && !done_o && !err_o && cfg_addr_o == 6'h10, "R8", "start while running",
                    int'(done_o), 0);
            end else begin
                chk(phy_rst_o == 1'b1, "R7", "reset on timeout", int'(phy_rst_o), 1);
                repeat (10) @(negedge clk);
                chk(err_o && phy_rst_o, "R7", "error held", int'(err_o), 1);
            end
        end

        // R10: restart from failed state
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        chk(!err_o && !phy_rst_o && cfg_addr_o == 6'h10, "R10", "restart clears error", int'(err_o), 0);

        // R8: start during lock wait does not restart the timeout
        power_down();
        run_scn(NEVER, NEVER, NEVER, 0, 20);
        chk(got_err == 1 && got_cyc == 40, "R8", "timeout cycle with mid-wait start", got_cyc, 40);

        // R9: power-off from running state
        power_down();
        run_scn(0, NEVER, NEVER, 0, -1);
        @(negedge clk); pwr_off_i = 1'b1;
        @(negedge clk); pwr_off_i = 1'b0;
        chk(lane_off_o && !phy_rst_o, "R9", "lane off before reset", {lane_off_o, phy_rst_o}, 2);
        @(negedge clk);
        chk(lane_off_o && phy_rst_o, "R9", "reset after lane off", {lane_off_o, phy_rst_o}, 3);

        // R9: power-off in the middle of the write phase
        @(negedge clk); start_i = 1'b1; pll_locked_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        repeat (4) @(negedge clk);
        pwr_off_i = 1'b1;
        @(negedge clk); pwr_off_i = 1'b0;
        chk(lane_off_o && !phy_rst_o && !cfg_wr_o, "R9", "mid-write power-off", {lane_off_o, phy_rst_o}, 2);
        @(negedge clk);
        chk(lane_off_o && phy_rst_o, "R9", "mid-write reset", {lane_off_o, phy_rst_o}, 3);

        finish_run();
    end

endmodule